// File: doc/BRIEF.md
# Nibble-Command Register Port

This block gives a host a byte-wide command path into a small register bank. Every command byte carries an opcode in bits [7:4] and a four-bit payload in bits [3:0]. The host builds an 8-bit register address from two address commands and stages the low half of a data byte. It then writes the register with a command that carries the high half. A read command returns the addressed register as two response bytes.

The bank holds a set of configuration bytes for a capture engine and a capture control register. That control register drives three held enables and four single-cycle action strobes. On the read side the bank shows a device identifier and several 24-bit and 16-bit capture positions. These come from the engine, one byte per address. It also shows a status byte that merges the held enables with three engine flags. Writes and reads advance the address by one, so the host can stream a multi-byte field without reloading the address.

Top module: `nib_reg_port`

## Requirements
- R1: After reset every configuration output, enable and strobe is 0, `rsp_valid_o` is low and the address is 0.
- R2: Opcode 0 replaces address bits [3:0] with the payload and opcode 1 replaces address bits [7:4] with it. The other half of the address is kept.
- R3: Opcode 2 stores the payload as the staged low data nibble, and the staged nibble stays until the next opcode 2. Opcode 3 writes {payload, staged nibble} to the addressed register. It then advances the address by one, and address 255 wraps to 0.
- R4: Write addresses: 0 `clk_sel_o`, 1 `trig_sel_o[7:0]`, 2 `trig_sel_o[15:8]`, 4 `mem_row_o`, 5 `post_trig_o`, 6 `trig_opt_o`, 7 `pin_view_o`, 15 `test_o`. A write to any other address other than 3 changes no output.
- R5: A write to address 3 sets three held levels: bit 0 `dram_wr_en_o`, bit 1 `dram_rd_en_o` and bit 3 `trig_en_o`.
- R6: A write to address 3 drives the strobes for exactly one cycle after the write, one for each data bit that is set: bit 2 `trig_reset_o`, bit 4 `force_stop_o`, bit 5 `sw_trig_o` and bit 7 `dram_init_o`. Bit 6 has no effect.
- R7: Opcode 4 makes `rsp_valid_o` high for the next two cycles. The first byte carries bits [3:0] of the addressed register and the second carries bits [7:4]. In both bytes the nibble sits in bits [3:0] and bits [7:4] are 0. The address then advances by one.
- R8: Read addresses:
  - 0 returns the `DEV_ID` parameter.
  - 1, 2 and 3 return bytes 0, 1 and 2 of `trig_pos_i`.
  - 4, 5 and 6 return bytes 0, 1 and 2 of `stop_pos_i`.
  - 8 and 9 return bytes 0 and 1 of `pin_change_i`.
  - 10 and 11 return bytes 0 and 1 of `last_ts_i`.
  - 12 returns `pin_view_o` and 15 returns `test_o`.
  - Every other address returns 0.
- R9: Read address 7 returns a status byte:
  - bit 0 is `dram_wr_en_o`, bit 1 is `dram_rd_en_o` and bit 3 is `trig_en_o`.
  - bit 4 is `round_i`, bit 5 is `triggered_i` and bit 6 is `post_done_i`.
  - bits 2 and 7 are 0.
- R10: A command with opcode 5 to 15, or any byte while `cmd_valid_i` is low, changes no register, no address and no staged nibble, and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command byte present this cycle |
| cmd_i | input | 8 | Opcode [7:4], payload [3:0] |
| rsp_valid_o | output | 1 | Response byte present |
| rsp_o | output | 8 | Response nibble in [3:0] |
| clk_sel_o | output | 8 | Clock selection byte |
| trig_sel_o | output | 16 | Trigger selection, two bytes |
| mem_row_o | output | 8 | Memory row byte |
| post_trig_o | output | 8 | Post-trigger byte |
| trig_opt_o | output | 8 | Trigger option byte |
| pin_view_o | output | 8 | Pin view byte |
| test_o | output | 8 | Scratch byte |
| dram_wr_en_o | output | 1 | Held memory write enable |
| dram_rd_en_o | output | 1 | Held memory read enable |
| trig_en_o | output | 1 | Held trigger enable |
| trig_reset_o | output | 1 | Trigger reset strobe |
| force_stop_o | output | 1 | Force stop strobe |
| sw_trig_o | output | 1 | Software trigger strobe |
| dram_init_o | output | 1 | Memory init strobe |
| trig_pos_i | input | 24 | Trigger position |
| stop_pos_i | input | 24 | Stop position |
| round_i | input | 1 | Memory wrapped flag |
| triggered_i | input | 1 | Triggered flag |
| post_done_i | input | 1 | Post-trigger done flag |
| pin_change_i | input | 16 | Pin change word |
| last_ts_i | input | 16 | Last block timestamp |

## Verification
The tests are built from command sequences chosen to separate the ways the decoder could go wrong.

Writing every mapped register with a distinct value shows whether the address is decoded correctly. A run of two commits that share one staged nibble shows whether the nibble is held and whether the address advances. Three mode bytes separate the held levels from the strobes and from the dead bit 6: one with only the level bits set, one with only the strobe bits set, and one with only bit 6 set.

A sixteen-read sweep from address 0 checks the read map, the status merge, the nibble order and the advance after each read. Loading a single address nibble, issuing opcodes 5 to 15, and committing at address 255 expose corruption of the other half of the address, stray responses and a missing wrap.

// File: rtl/nib_reg_pkg.sv
package nib_reg_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int N_WREG = 8;

  typedef enum logic [NIB_W-1:0] {
    OP_ADDR_LO = 4'h0,
    OP_ADDR_HI = 4'h1,
    OP_DATA_LO = 4'h2,
    OP_DATA_HI = 4'h3,
    OP_READ    = 4'h4
  } opcode_e;

  localparam logic [NIB_W-1:0] WA_MODE = 4'd3;
  // storage slot -> write address
  localparam logic [NIB_W-1:0] WR_ADDR [N_WREG] =
    '{4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7, 4'd15};

  // control byte bit positions
  localparam int CB_WREN  = 0;
  localparam int CB_RDEN  = 1;
  localparam int CB_TRST  = 2;
  localparam int CB_TEN   = 3;
  localparam int CB_FSTOP = 4;
  localparam int CB_SWTRG = 5;
  localparam int CB_INIT  = 7;
endpackage

// File: rtl/nib_cmd_decode.sv
module nib_cmd_decode
  import nib_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [BYTE_W-1:0] cmd_i,
  output logic [BYTE_W-1:0] addr_o,
  output logic              wr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_o
);
  opcode_e          op;
  logic [NIB_W-1:0] pay;
  logic [BYTE_W-1:0] addr_q;
  logic [NIB_W-1:0] dlo_q;

  always_comb begin
    op        = opcode_e'(cmd_i[BYTE_W-1:NIB_W]);
    pay       = cmd_i[NIB_W-1:0];
    wr_o      = cmd_valid_i && (op == OP_DATA_HI);
    rd_o      = cmd_valid_i && (op == OP_READ);
    wr_data_o = {pay, dlo_q};
    addr_o    = addr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      dlo_q  <= '0;
    end else if (cmd_valid_i) begin
      unique case (op)
        OP_ADDR_LO: addr_q[NIB_W-1:0]        <= pay;
        OP_ADDR_HI: addr_q[BYTE_W-1:NIB_W]   <= pay;
        OP_DATA_LO: dlo_q                    <= pay;
        OP_DATA_HI,
        OP_READ:    addr_q                   <= addr_q + 1'b1;
        default: ;
      endcase
    end
  end

  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o || rd_o) |=> addr_q == $past(addr_q) + 8'd1);
  // R10
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_valid_i || cmd_i[7:4] > 4'h4) |=> $stable(addr_q) && $stable(dlo_q));
  // R2
  addr_lo_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i[7:4] == 4'h0) |=> addr_q[7:4] == $past(addr_q[7:4]));
endmodule

// File: rtl/nib_wr_regs.sv
module nib_wr_regs
  import nib_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] wreg_o [N_WREG],
  output logic [2:0]        lvl_o,
  output logic [3:0]        pulse_o
);
  logic lo_page;
  logic mode_hit;
  logic [2:0] lvl_q;
  logic [3:0] pulse_q;

  assign lo_page  = (addr_i[BYTE_W-1:NIB_W] == '0);
  assign mode_hit = wr_i && lo_page && (addr_i[NIB_W-1:0] == WA_MODE);

  for (genvar i = 0; i < N_WREG; i++) begin : g_wreg
    logic [BYTE_W-1:0] r_q;
    logic hit;
    assign hit = wr_i && lo_page && (addr_i[NIB_W-1:0] == WR_ADDR[i]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  r_q <= '0;
      else if (hit) r_q <= data_i;
    end
    assign wreg_o[i] = r_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= '0;
      pulse_q <= '0;
    end else begin
      pulse_q <= '0;
      if (mode_hit) begin
        lvl_q   <= {data_i[CB_TEN], data_i[CB_RDEN], data_i[CB_WREN]};
        pulse_q <= {data_i[CB_INIT], data_i[CB_SWTRG], data_i[CB_FSTOP], data_i[CB_TRST]};
      end
    end
  end

  assign lvl_o   = lvl_q;
  assign pulse_o = pulse_q;

  // R6
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q != 4'd0) |=> (pulse_q == 4'd0));
  // R6
  strobe_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q != 4'd0) |-> $past(wr_i && addr_i == 8'd3));
  // R5
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == 8'd3) |=> $stable(lvl_q));
endmodule

// File: rtl/nib_rd_mux.sv
module nib_rd_mux
  import nib_reg_pkg::*;
#(
  parameter logic [7:0] DEV_ID = 8'h3C,
  parameter int POS_W = 24,
  parameter int WORD_W = 16
) (
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [2:0]        lvl_i,
  input  logic [BYTE_W-1:0] pin_view_i,
  input  logic [BYTE_W-1:0] test_i,
  input  logic [POS_W-1:0]  trig_pos_i,
  input  logic [POS_W-1:0]  stop_pos_i,
  input  logic              round_i,
  input  logic              triggered_i,
  input  logic              post_done_i,
  input  logic [WORD_W-1:0] pin_change_i,
  input  logic [WORD_W-1:0] last_ts_i,
  output logic [BYTE_W-1:0] data_o
);
  logic [BYTE_W-1:0] status;

  always_comb begin
    status = '0;
    status[0] = lvl_i[0];
    status[1] = lvl_i[1];
    status[3] = lvl_i[2];
    status[4] = round_i;
    status[5] = triggered_i;
    status[6] = post_done_i;
  end

  always_comb begin
    data_o = '0;
    if (addr_i[BYTE_W-1:NIB_W] == '0) begin
      unique case (addr_i[NIB_W-1:0])
        4'd0:  data_o = DEV_ID;
        4'd1:  data_o = trig_pos_i[7:0];
        4'd2:  data_o = trig_pos_i[15:8];
        4'd3:  data_o = trig_pos_i[23:16];
        4'd4:  data_o = stop_pos_i[7:0];
        4'd5:  data_o = stop_pos_i[15:8];
        4'd6:  data_o = stop_pos_i[23:16];
        4'd7:  data_o = status;
        4'd8:  data_o = pin_change_i[7:0];
        4'd9:  data_o = pin_change_i[15:8];
        4'd10: data_o = last_ts_i[7:0];
        4'd11: data_o = last_ts_i[15:8];
        4'd12: data_o = pin_view_i;
        4'd15: data_o = test_i;
        default: data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/nib_rsp_ser.sv
module nib_rsp_ser
  import nib_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              rsp_valid_o,
  output logic [BYTE_W-1:0] rsp_o
);
  logic             pend_q;
  logic [NIB_W-1:0] hi_q;
  logic             valid_q;
  logic [BYTE_W-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      hi_q    <= '0;
      valid_q <= 1'b0;
      out_q   <= '0;
    end else if (rd_i) begin
      pend_q  <= 1'b1;
      hi_q    <= byte_i[BYTE_W-1:NIB_W];
      valid_q <= 1'b1;
      out_q   <= {{NIB_W{1'b0}}, byte_i[NIB_W-1:0]};
    end else if (pend_q) begin
      pend_q  <= 1'b0;
      valid_q <= 1'b1;
      out_q   <= {{NIB_W{1'b0}}, hi_q};
    end else begin
      valid_q <= 1'b0;
      out_q   <= '0;
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_o       = out_q;

  // R7
  rsp_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rsp_valid_o ##1 rsp_valid_o);
  // R7
  rsp_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_o[7:4] == 4'h0);
  // R10
  rsp_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) |-> $past(rd_i));
endmodule

// File: rtl/nib_reg_port.sv
module nib_reg_port
  import nib_reg_pkg::*;
#(
  parameter logic [7:0] DEV_ID = 8'h3C,
  parameter int POS_W = 24,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_i,
  output logic              rsp_valid_o,
  output logic [7:0]        rsp_o,
  output logic [7:0]        clk_sel_o,
  output logic [15:0]       trig_sel_o,
  output logic [7:0]        mem_row_o,
  output logic [7:0]        post_trig_o,
  output logic [7:0]        trig_opt_o,
  output logic [7:0]        pin_view_o,
  output logic [7:0]        test_o,
  output logic              dram_wr_en_o,
  output logic              dram_rd_en_o,
  output logic              trig_en_o,
  output logic              trig_reset_o,
  output logic              force_stop_o,
  output logic              sw_trig_o,
  output logic              dram_init_o,
  input  logic [POS_W-1:0]  trig_pos_i,
  input  logic [POS_W-1:0]  stop_pos_i,
  input  logic              round_i,
  input  logic              triggered_i,
  input  logic              post_done_i,
  input  logic [WORD_W-1:0] pin_change_i,
  input  logic [WORD_W-1:0] last_ts_i
);
  logic [BYTE_W-1:0] addr;
  logic              wr, rd;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] wreg [N_WREG];
  logic [2:0]        lvl;
  logic [3:0]        pulse;
  logic [BYTE_W-1:0] rd_data;

  nib_cmd_decode u_dec (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_i,
    .addr_o(addr), .wr_o(wr), .wr_data_o(wr_data), .rd_o(rd)
  );

  nib_wr_regs u_wr (
    .clk_i, .rst_ni, .addr_i(addr), .wr_i(wr), .data_i(wr_data),
    .wreg_o(wreg), .lvl_o(lvl), .pulse_o(pulse)
  );

  nib_rd_mux #(.DEV_ID(DEV_ID), .POS_W(POS_W), .WORD_W(WORD_W)) u_rd (
    .addr_i(addr), .lvl_i(lvl), .pin_view_i(wreg[6]), .test_i(wreg[7]),
    .trig_pos_i, .stop_pos_i, .round_i, .triggered_i, .post_done_i,
    .pin_change_i, .last_ts_i, .data_o(rd_data)
  );

  nib_rsp_ser u_rsp (
    .clk_i, .rst_ni, .rd_i(rd), .byte_i(rd_data),
    .rsp_valid_o, .rsp_o
  );

  assign clk_sel_o    = wreg[0];
  assign trig_sel_o   = {wreg[2], wreg[1]};
  assign mem_row_o    = wreg[3];
  assign post_trig_o  = wreg[4];
  assign trig_opt_o   = wreg[5];
  assign pin_view_o   = wreg[6];
  assign test_o       = wreg[7];
  assign dram_wr_en_o = lvl[0];
  assign dram_rd_en_o = lvl[1];
  assign trig_en_o    = lvl[2];
  assign trig_reset_o = pulse[0];
  assign force_stop_o = pulse[1];
  assign sw_trig_o    = pulse[2];
  assign dram_init_o  = pulse[3];
endmodule

// File: tb/nib_reg_port_test.sv
module nib_reg_port_test;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] ID = 8'h3C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd = '0;
  logic rsp_valid;
  logic [7:0] rsp;
  logic [7:0] clk_sel, mem_row, post_trig, trig_opt, pin_view, test_r;
  logic [15:0] trig_sel;
  logic wr_en, rd_en, t_en, t_rst, f_stop, s_trg, d_init;
  logic [23:0] trig_pos = 24'hC3B2A1, stop_pos = 24'hF6E5D4;
  logic round = 1'b1, triggered = 1'b0, post_done = 1'b1;
  logic [15:0] pin_change = 16'h8877, last_ts = 16'hAA99;

  int n_chk = 0, n_err = 0;
  logic [7:0] exp_q[$];
  string req_q[$];
  logic [7:0] m_reg [16];
  logic [2:0] m_lvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  nib_reg_port #(.DEV_ID(ID)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .rsp_valid_o(rsp_valid), .rsp_o(rsp),
    .clk_sel_o(clk_sel), .trig_sel_o(trig_sel), .mem_row_o(mem_row),
    .post_trig_o(post_trig), .trig_opt_o(trig_opt), .pin_view_o(pin_view),
    .test_o(test_r), .dram_wr_en_o(wr_en), .dram_rd_en_o(rd_en),
    .trig_en_o(t_en), .trig_reset_o(t_rst), .force_stop_o(f_stop),
    .sw_trig_o(s_trg), .dram_init_o(d_init),
    .trig_pos_i(trig_pos), .stop_pos_i(stop_pos), .round_i(round),
    .triggered_i(triggered), .post_done_i(post_done),
    .pin_change_i(pin_change), .last_ts_i(last_ts)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd = '0;
  endtask

  task automatic set_addr(logic [7:0] a);
    send({4'h0, a[3:0]});
    send({4'h1, a[7:4]});
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    set_addr(a);
    send({4'h2, d[3:0]});
    send({4'h3, d[7:4]});
    if (a < 8'd16 && a != 8'd3) m_reg[a[3:0]] = d;
    if (a == 8'd3) m_lvl = {d[3], d[1], d[0]};
  endtask

  function automatic logic [7:0] rd_model(logic [7:0] a);
    if (a >= 8'd16) return 8'h00;
    case (a[3:0])
      4'd0: return ID;
      4'd1: return trig_pos[7:0];
      4'd2: return trig_pos[15:8];
      4'd3: return trig_pos[23:16];
      4'd4: return stop_pos[7:0];
      4'd5: return stop_pos[15:8];
      4'd6: return stop_pos[23:16];
      4'd7: return {1'b0, post_done, triggered, round, m_lvl[2], 1'b0, m_lvl[1], m_lvl[0]};
      4'd8: return pin_change[7:0];
      4'd9: return pin_change[15:8];
      4'd10: return last_ts[7:0];
      4'd11: return last_ts[15:8];
      4'd12: return m_reg[7];
      4'd15: return m_reg[15];
      default: return 8'h00;
    endcase
  endfunction

  task automatic rd_expect(logic [7:0] e, string req);
    exp_q.push_back({4'h0, e[3:0]}); req_q.push_back(req);
    exp_q.push_back({4'h0, e[7:4]}); req_q.push_back(req);
    send(8'h40);
    @(negedge clk);
  endtask

  task automatic chk_wregs(string req);
    chk(req, clk_sel, m_reg[0]);
    chk(req, trig_sel, {m_reg[2], m_reg[1]});
    chk(req, mem_row, m_reg[4]);
    chk(req, post_trig, m_reg[5]);
    chk(req, trig_opt, m_reg[6]);
    chk(req, pin_view, m_reg[7]);
    chk(req, test_r, m_reg[15]);
  endtask

  // monitor: pop expected response bytes as they appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R10: unexpected response actual %0h expected none", rsp);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        chk(r, rsp, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_reg[i] = '0;
    m_lvl = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_wregs("R1");
    chk("R1", {wr_en, rd_en, t_en, t_rst, f_stop, s_trg, d_init, rsp_valid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", rsp_valid, 1'b0);
    rd_expect(ID, "R1 address 0");

    // R4 every mapped write register
    wr(8'd0, 8'h11); wr(8'd1, 8'h22); wr(8'd2, 8'h33); wr(8'd4, 8'h44);
    wr(8'd5, 8'h55); wr(8'd6, 8'h66); wr(8'd7, 8'h5E); wr(8'd15, 8'h7F);
    chk_wregs("R4");

    // R3 staged nibble reused, address advances after commit
    set_addr(8'd1);
    send(8'h24);
    send(8'h3A); m_reg[1] = 8'hA4;
    send(8'h3B); m_reg[2] = 8'hB4;
    chk("R3", trig_sel, 16'hB4A4);

    // R4 unmapped writes ignored
    wr(8'd8, 8'hFF); wr(8'h28, 8'hFF); wr(8'd13, 8'hEE);
    chk_wregs("R4 unmapped");

    // R5 held levels, no strobes
    wr(8'd3, 8'h0B);
    chk("R5", {wr_en, rd_en, t_en}, 3'b111);
    chk("R6 no strobe", {t_rst, f_stop, s_trg, d_init}, 4'b0000);
    // R6 strobes for one cycle
    wr(8'd3, 8'hB4);
    chk("R6", {t_rst, f_stop, s_trg, d_init}, 4'b1111);
    chk("R5 cleared", {wr_en, rd_en, t_en}, 3'b000);
    @(negedge clk);
    chk("R6 one cycle", {t_rst, f_stop, s_trg, d_init}, 4'b0000);
    // R6 bit 6 dead
    wr(8'd3, 8'h40);
    chk("R6 bit6", {t_rst, f_stop, s_trg, d_init, wr_en, rd_en, t_en}, 7'h00);
    wr(8'd3, 8'h0B);

    // R7 R8 R9 sweep with auto-increment
    set_addr(8'd0);
    for (int a = 0; a < 16; a++)
      rd_expect(rd_model(8'(a)), a == 7 ? "R9" : "R8");
    set_addr(8'h8C);
    rd_expect(8'h00, "R8 high page");

    // R10 illegal opcodes and invalid cycles
    set_addr(8'd5);
    send(8'h5F); send(8'hAF); send(8'hFF); send(8'h93);
    @(negedge clk); cmd = 8'h3F;
    @(negedge clk); cmd = 8'h40;
    @(negedge clk); cmd = '0;
    rd_expect(stop_pos[15:8] & 8'h00 | rd_model(8'd5), "R10");
    chk_wregs("R10");

    // R2 nibble loads keep the other half
    set_addr(8'h3C);
    send(8'h10);
    rd_expect(m_reg[7], "R2 hi");
    send(8'h07);
    rd_expect(rd_model(8'd7), "R2 lo");

    // R3 wrap 255 -> 0
    set_addr(8'hFF);
    send(8'h21); send(8'h31);
    rd_expect(ID, "R3 wrap");
    chk_wregs("R3 wrap");

    repeat (4) @(negedge clk);
    chk("R7 drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule